// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

This block sits between two 16-bit buses, called A and B, and splits them into two byte lanes that work independently. Lane 0 covers bits 7..0 and lane 1 covers bits 15..8. Each lane drives at most one of the two buses. The driven bus carries either the live value from the opposite bus or a value that an earlier clock pulse stored. All paths are non-inverting. If both lanes get the same control values, the block acts as a single 16-bit transceiver.

Each lane has an A-side store and a B-side store. The A-side store takes the lane's A-bus value on a rising edge of that lane's A capture clock. The B-side store takes the lane's B-bus value on a rising edge of that lane's B capture clock. Storing continues even while the lane's outputs are isolated. The bidirectional pins appear as separate input, output and per-lane drive-enable ports, so the pad buffers can stay outside the block.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Control bit k (k = 0 or 1) of every control port acts only on bus bits 8k+7..8k. A control setting or capture pulse on one lane leaves the other lane's outputs and stores unchanged.
- R2: A rising edge of `clk_ab[k]` loads lane k of `a_in` into the lane's A store. A rising edge of `clk_ba[k]` loads lane k of `b_in` into the lane's B store. Both loads happen whatever the values of `oe_n` and `dir`.
- R3: When `oe_n[k]` is 1, `a_drive[k]` and `b_drive[k]` are both 0.
- R4: When `oe_n[k]` is 0, `dir[k]` = 1 sets `b_drive[k]`=1 and `a_drive[k]`=0, and `dir[k]` = 0 sets `a_drive[k]`=1 and `b_drive[k]`=0. The two drive enables of a lane are never both 1.
- R5: When lane k drives B and `sel_ab[k]` is 0, lane k of `b_out` follows lane k of `a_in` combinationally.
- R6: When lane k drives B and `sel_ab[k]` is 1, lane k of `b_out` shows the lane's A store.
- R7: When lane k drives A and `sel_ba[k]` is 0, lane k of `a_out` follows lane k of `b_in` combinationally.
- R8: When lane k drives A and `sel_ba[k]` is 1, lane k of `a_out` shows the lane's B store.
- R9: When `rst_n` is 0, every store is cleared to zero at once, with no clock edge needed.
- R10: When a lane's drive enable for a bus is 0, that lane's bits of the matching output port are 0.
- R11: If a lane is in stored mode on a bus, a capture edge on the store that feeds that bus shows the newly captured value on the output straight after the edge, with no further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all stores |
| oe_n | input | 2 | Per-lane output enable, active low |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| clk_ab | input | 2 | Per-lane capture clock for the A store |
| clk_ba | input | 2 | Per-lane capture clock for the B store |
| sel_ab | input | 2 | Per-lane source for B: 0 live A, 1 A store |
| sel_ba | input | 2 | Per-lane source for A: 0 live B, 1 B store |
| a_in | input | 16 | Value seen on bus A |
| b_in | input | 16 | Value seen on bus B |
| a_out | output | 16 | Value to put on bus A |
| b_out | output | 16 | Value to put on bus B |
| a_drive | output | 2 | Per-lane enable for the bus A pad buffers |
| b_drive | output | 2 | Per-lane enable for the bus B pad buffers |

## Verification
The outputs, the drive enables and the transparent paths are purely combinational. A change to a control or data input shows up in the same step, so the bench applies each change half a bench-clock period after an edge and compares 1 ns later. A store changes only on the edge of its own capture pulse or when reset is asserted. The bench raises a capture pulse, waits 1 ns and then checks. This confirms that the stored-mode output has already taken the new value (R11) while the transparent paths are unaffected. A reference copy of the stores, updated in the bench at each pulse it issues, gives the expected value for every control combination of both lanes.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    // Which bus (if any) a lane is driving
    typedef enum logic [1:0] {
        PATH_ISOLATE = 2'd0,
        PATH_TO_A    = 2'd1,
        PATH_TO_B    = 2'd2
    } path_e;

    // Source of the driven bus
    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;
endpackage

// File: rtl/lane_store.sv
module lane_store #(
    parameter int W = 8
) (
    input  logic         cap_clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = d;
    end

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/lane_route.sv
module lane_route
    import bus_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_live,
    input  logic [W-1:0] b_live,
    input  logic [W-1:0] a_held,
    input  logic [W-1:0] b_held,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drv,
    output logic         b_drv
);
    path_e path;
    src_e  src_b, src_a;

    always_comb begin
        if (oe_n)     path = PATH_ISOLATE;
        else if (dir) path = PATH_TO_B;
        else          path = PATH_TO_A;
        src_b = src_e'(sel_ab);
        src_a = src_e'(sel_ba);
    end

    always_comb begin
        a_drv = 1'b0;
        b_drv = 1'b0;
        a_out = '0;
        b_out = '0;
        unique case (path)
            PATH_TO_B: begin
                b_drv = 1'b1;
                b_out = (src_b == SRC_HELD) ? a_held : a_live;
            end
            PATH_TO_A: begin
                a_drv = 1'b1;
                a_out = (src_a == SRC_HELD) ? b_held : b_live;
            end
            default: begin
                a_drv = 1'b0;
                b_drv = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drv,
    output logic         b_drv
);
    logic [W-1:0] a_held;
    logic [W-1:0] b_held;

    // A-side store: samples bus A on its own clock, independent of outputs
    lane_store #(.W(W)) u_store_a (
        .cap_clk (clk_ab),
        .rst_n   (rst_n),
        .d       (a_in),
        .q       (a_held)
    );

    // B-side store
    lane_store #(.W(W)) u_store_b (
        .cap_clk (clk_ba),
        .rst_n   (rst_n),
        .d       (b_in),
        .q       (b_held)
    );

    lane_route #(.W(W)) u_route (
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_live (a_in),
        .b_live (b_in),
        .a_held (a_held),
        .b_held (b_held),
        .a_out  (a_out),
        .b_out  (b_out),
        .a_drv  (a_drv),
        .b_drv  (b_drv)
    );
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             rst_n,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] clk_ab,
    input  logic [LANES-1:0] clk_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] a_drive,
    output logic [LANES-1:0] b_drive
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.W(LANE_W)) u_lane (
            .rst_n  (rst_n),
            .oe_n   (oe_n[g]),
            .dir    (dir[g]),
            .clk_ab (clk_ab[g]),
            .clk_ba (clk_ba[g]),
            .sel_ab (sel_ab[g]),
            .sel_ba (sel_ba[g]),
            .a_in   (a_in[g*LANE_W +: LANE_W]),
            .b_in   (b_in[g*LANE_W +: LANE_W]),
            .a_out  (a_out[g*LANE_W +: LANE_W]),
            .b_out  (b_out[g*LANE_W +: LANE_W]),
            .a_drv  (a_drive[g]),
            .b_drv  (b_drive[g])
        );
    end
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input logic             rst_n,
    input logic [LANES-1:0] oe_n,
    input logic [LANES-1:0] dir,
    input logic [LANES-1:0] clk_ab,
    input logic [LANES-1:0] clk_ba,
    input logic [LANES-1:0] sel_ab,
    input logic [LANES-1:0] sel_ba,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] b_in,
    input logic [BUS_W-1:0] a_out,
    input logic [BUS_W-1:0] b_out,
    input logic [LANES-1:0] a_drive,
    input logic [LANES-1:0] b_drive
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        logic ab_seen, ba_seen;

        // Set once a capture edge has occurred since the last reset
        always_ff @(posedge clk_ab[g] or negedge rst_n) begin
            if (!rst_n) ab_seen <= 1'b0;
            else        ab_seen <= 1'b1;
        end
        always_ff @(posedge clk_ba[g] or negedge rst_n) begin
            if (!rst_n) ba_seen <= 1'b0;
            else        ba_seen <= 1'b1;
        end

        AST_NO_DUAL_DRIVE: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            !(a_drive[g] && b_drive[g])); // R4

        AST_ISO_QUIET: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            oe_n[g] |-> (!a_drive[g] && !b_drive[g])); // R3

        AST_IDLE_A_ZERO: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            !a_drive[g] |-> (a_out[g*LANE_W +: LANE_W] == '0)); // R10

        AST_A_HELD: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            (ab_seen && !oe_n[g] && dir[g] && sel_ab[g])
            |-> (b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W]))); // R6

        AST_B_HELD: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            (ba_seen && !oe_n[g] && !dir[g] && sel_ba[g])
            |-> (a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W]))); // R8
    end
endmodule

bind bus_xcvr_reg bus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  oe_n, dir, clk_ab, clk_ba, sel_ab, sel_ba;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_drive, b_drive;

    logic [7:0]  ma [2];
    logic [7:0]  mb [2];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_xcvr_reg u0 (
        .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .clk_ab(clk_ab), .clk_ba(clk_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive)
    );

    task automatic check_lanes(input string note);
        for (int k = 0; k < 2; k++) begin
            logic [7:0] ea, eb;
            logic       eda, edb;
            string      req;
            ea = 8'h00; eb = 8'h00; eda = 1'b0; edb = 1'b0;
            if (oe_n[k]) req = "R3/R10";
            else if (dir[k]) begin
                edb = 1'b1;
                eb  = sel_ab[k] ? ma[k] : a_in[k*8 +: 8];
                req = sel_ab[k] ? "R4/R6" : "R4/R5";
            end else begin
                eda = 1'b1;
                ea  = sel_ba[k] ? mb[k] : b_in[k*8 +: 8];
                req = sel_ba[k] ? "R4/R8" : "R4/R7";
            end
            checks++;
            if (a_out[k*8 +: 8] !== ea || b_out[k*8 +: 8] !== eb ||
                a_drive[k] !== eda || b_drive[k] !== edb) begin
                errors++;
                $display("FAIL %s %s R1 lane %0d: act a=%h b=%h da=%b db=%b exp a=%h b=%h da=%b db=%b",
                         note, req, k, a_out[k*8 +: 8], b_out[k*8 +: 8], a_drive[k], b_drive[k],
                         ea, eb, eda, edb);
            end
        end
    endtask

    task automatic apply(input logic [1:0] oe, input logic [1:0] di, input logic [1:0] sab,
                         input logic [1:0] sba, input logic [15:0] a, input logic [15:0] b,
                         input string note);
        @(negedge clk);
        oe_n = oe; dir = di; sel_ab = sab; sel_ba = sba; a_in = a; b_in = b;
        #1 check_lanes(note);
    endtask

    task automatic pulse_ab(input logic [1:0] lanes, input string note);
        @(negedge clk);
        clk_ab = lanes;
        for (int k = 0; k < 2; k++) if (lanes[k]) ma[k] = a_in[k*8 +: 8];
        #1 check_lanes(note);
        #0.5 clk_ab = 2'b00;
    endtask

    task automatic pulse_ba(input logic [1:0] lanes, input string note);
        @(negedge clk);
        clk_ba = lanes;
        for (int k = 0; k < 2; k++) if (lanes[k]) mb[k] = b_in[k*8 +: 8];
        #1 check_lanes(note);
        #0.5 clk_ba = 2'b00;
    endtask

    task automatic do_reset(input string note);
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 2; k++) begin ma[k] = 8'h00; mb[k] = 8'h00; end
        #1 check_lanes(note);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: act running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = 2'b11; dir = 2'b00; clk_ab = 2'b00; clk_ba = 2'b00;
        sel_ab = 2'b00; sel_ba = 2'b00; a_in = 16'h0000; b_in = 16'h0000;
        for (int k = 0; k < 2; k++) begin ma[k] = 8'h00; mb[k] = 8'h00; end
        #1 check_lanes("reset isolation R3");
        // R9: reset state of stores seen through stored mode on both buses
        apply(2'b00, 2'b11, 2'b11, 2'b11, 16'hFFFF, 16'hFFFF, "R9 reset A store zero");
        apply(2'b00, 2'b00, 2'b11, 2'b11, 16'hFFFF, 16'hFFFF, "R9 reset B store zero");
        @(negedge clk); rst_n = 1'b1;

        // R2: capture while isolated, then replay
        apply(2'b11, 2'b10, 2'b11, 2'b11, 16'h3C5A, 16'h96E1, "R3 isolated");
        pulse_ab(2'b11, "R2 capture A isolated");
        pulse_ba(2'b11, "R2 capture B isolated");
        apply(2'b00, 2'b11, 2'b11, 2'b11, 16'h0000, 16'h0000, "R2 replay A store");
        apply(2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'h0000, "R2 replay B store");

        // Sweep every control combination, lanes deliberately different (R1)
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 3; p++) begin
                logic [1:0] oe, di, sab, sba;
                logic [15:0] a, b;
                oe  = {~c[0], c[0]};
                di  = {~c[1], c[1]};
                sab = {~c[2], c[2]};
                sba = {~c[3], c[3]};
                a = 16'((c * 4663 + p * 977 + 17) ^ 16'hA5C3);
                b = 16'((c * 2719 + p * 3301 + 91) ^ 16'h5A3C);
                apply(oe, di, sab, sba, a, b, "R1 sweep");
                pulse_ab(2'(p + 1), "R11 A capture, R1 one-lane pulse");
                apply(oe, di, sab, sba, ~a, b ^ 16'h0FF0, "R5 R6 data change after A capture");
                pulse_ba(2'(3 - p), "R11 B capture, R1 one-lane pulse");
                apply(oe, di, sab, sba, a ^ 16'hF00F, ~b, "R7 R8 data change after B capture");
            end
        end

        // R11: stored mode on B, repeated captures show immediately
        apply(2'b00, 2'b11, 2'b11, 2'b00, 16'h1234, 16'h0000, "R6 stored B setup");
        pulse_ab(2'b11, "R11 capture and output to B");
        apply(2'b00, 2'b11, 2'b11, 2'b00, 16'hABCD, 16'h0000, "R6 held after input change");
        pulse_ab(2'b01, "R11 lane0 only, R1 lane1 held");

        // R9: asynchronous clear mid-run with stores loaded
        apply(2'b00, 2'b01, 2'b11, 2'b11, 16'h7E81, 16'hC33C, "R9 preload");
        pulse_ba(2'b11, "R2 preload B");
        do_reset("R9 async clear");
        apply(2'b00, 2'b10, 2'b11, 2'b11, 16'h5555, 16'hAAAA, "R9 cleared stores");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule